// File: doc/BRIEF.md
# PLL Tuning and Reset Sequencer

This block holds the tuning word that trims an on-chip PLL and sequences the reset that has to follow a change to that word. Software reaches it through a small register bus with two registers. The access-control register carries an enable bit and a read-only flag. The flag shows whether the single tuning change allowed since power-on has been spent. The tuning register is writable only while the enable bit is set, and only once per power-on. A read of it always returns the word currently driven to the PLL.

An accepted tuning write starts a fixed-length reset pulse. During the pulse the block drives the processor's hard-reset line low, holds on-chip logic in reset through an internal active-low reset and holds the PLL in reset. It also clears its own enable bit. The new tuning word and the write-once flag survive the pulse. Only the active-low system reset input restores the factory tuning word and re-arms the single write. That input takes effect at once. Its release passes through a two-flop synchronizer.

The register bus is a plain single-cycle control port with no flow control. A write takes effect at the clock edge where `bus_wr` is high. Read data follows `bus_addr` combinationally.

Top module: `pll_tune_rst_ctrl`

## Requirements
- R1: While `sys_rst_n` is low, `rst_out_n` and `int_rst_n` are low and `pll_rst` is high. After `sys_rst_n` rises they stay in that state for two more rising clock edges. After that, the tuning word equals the `TUNE_DEFAULT` parameter, and both bits of the access register read 0.
- R2: The access register is word address 0. Its bit 0 is the read/write enable. Its bit 1 is the read-only write-once flag, and writes to bit 1 are ignored. Every other bit reads 0. The tuning register is word address 1 and returns the tuning word in its low `TUNE_W` bits. Any other address reads 0, and writes to it change nothing.
- R3: A write to the tuning register while the enable bit is 0 leaves the tuning word unchanged and starts no reset pulse.
- R4: A write to the tuning register while the enable bit is 1 and the flag is 0 loads the low `TUNE_W` bits of the write data into the tuning word and sets the flag.
- R5: Once the flag is set, writes to the tuning register leave the tuning word unchanged and start no reset pulse, even when the enable bit is set again.
- R6: After an accepted tuning write, `rst_out_n` and `int_rst_n` are low and `pll_rst` is high for exactly `PULSE_CYC` clock cycles. The pulse starts at the clock edge that accepts the write.
- R7: The reset pulse clears the enable bit. The new tuning word and the set flag are kept.
- R8: A system reset returns the tuning word to `TUNE_DEFAULT` and clears the flag, so that one more tuning write can be accepted.
- R9: All register writes made during the reset pulse are ignored.
- R10: `pll_tune` and a read of the tuning register always equal the current tuning word, including during the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset; asynchronous assert, synchronized release |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` |
| pll_tune | output | TUNE_W | Tuning word driven to the PLL |
| pll_rst | output | 1 | Active-high PLL reset |
| rst_out_n | output | 1 | Active-low hard reset to the processor |
| int_rst_n | output | 1 | Active-low reset to on-chip logic |

## Verification
On every cycle the assertions check four things. The tuning word is stable unless a write is accepted. The write-once flag never falls outside a system reset, and it rises only together with the reset pulse. The enable bit stays clear while the pulse runs, and the pulse counter counts down by one each cycle. Whether a blocked write leaves the PLL untouched, and how long the pulse lasts, are shown by the bench scenarios. So are the restoration of the factory word by a system reset and the synchronizer delay on reset release. The bench sweeps every tuning value through a complete power-on, refused write, accepted write, pulse and second write sequence.

// File: rtl/pll_tune_pkg.sv
package pll_tune_pkg;
  // Register word addresses (software-visible map)
  localparam int unsigned ADDR_ACCESS = 0;
  localparam int unsigned ADDR_TUNE   = 1;
  // Access register bit positions
  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_USED    = 1;
  // Depth of the reset-release synchronizer
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ptc_rst_sync.sv
module ptc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ptc_pulse_gen.sv
module ptc_pulse_gen #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    else if (start)        cnt_q <= CNT_LOAD;
  end

  assign active = (cnt_q != '0);

  // R6: an idle start loads the full pulse length
  a_r6_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> (cnt_q == CNT_LOAD));
  // R6: a running pulse counts down by exactly one per cycle
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
  import pll_tune_pkg::*;
#(
  parameter int unsigned ADDR_W       = 2,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned TUNE_W       = 8,
  parameter logic [TUNE_W-1:0] TUNE_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_active,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [TUNE_W-1:0] tune,
  output logic              acc_en,
  output logic              used,
  output logic              tune_accept
);
  logic [TUNE_W-1:0] tune_q;
  logic              en_q;
  logic              used_q;
  logic              sel_access;
  logic              sel_tune;
  logic              wr_access;

  assign sel_access  = (addr == ADDR_W'(ADDR_ACCESS));
  assign sel_tune    = (addr == ADDR_W'(ADDR_TUNE));
  assign wr_access   = wr && sel_access && !pulse_active;
  assign tune_accept = wr && sel_tune && en_q && !used_q && !pulse_active;

  // Tuning word and write-once flag: cleared only by the system reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q <= TUNE_DEFAULT;
      used_q <= 1'b0;
    end else if (tune_accept) begin
      tune_q <= wdata[TUNE_W-1:0];
      used_q <= 1'b1;
    end
  end

  // Enable bit: also cleared by the self-generated pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en_q <= 1'b0;
    else if (tune_accept || pulse_active) en_q <= 1'b0;
    else if (wr_access)              en_q <= wdata[BIT_EN];
  end

  always_comb begin
    rdata = '0;
    if (sel_access) begin
      rdata[BIT_EN]   = en_q;
      rdata[BIT_USED] = used_q;
    end else if (sel_tune) begin
      rdata[TUNE_W-1:0] = tune_q;
    end
  end

  assign tune   = tune_q;
  assign acc_en = en_q;
  assign used   = used_q;

  // R3/R5: the tuning word moves only on an accepted write
  a_r3_tune_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_accept |=> $stable(tune_q));
  // R5: the write-once flag never falls outside a system reset
  a_r5_used_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    used_q |=> used_q);
endmodule

// File: rtl/pll_tune_rst_ctrl.sv
module pll_tune_rst_ctrl
  import pll_tune_pkg::*;
#(
  parameter int unsigned ADDR_W       = 2,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned TUNE_W       = 8,
  parameter logic [TUNE_W-1:0] TUNE_DEFAULT = 8'h5A,
  parameter int unsigned PULSE_CYC    = 16
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [TUNE_W-1:0] pll_tune,
  output logic              pll_rst,
  output logic              rst_out_n,
  output logic              int_rst_n
);
  logic por_rst_n;
  logic pulse_active;
  logic tune_accept;
  logic acc_en;
  logic used;
  logic hold_n;

  ptc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .arst_n     (sys_rst_n),
    .rst_n_sync (por_rst_n)
  );

  ptc_regs #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .TUNE_W       (TUNE_W),
    .TUNE_DEFAULT (TUNE_DEFAULT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (por_rst_n),
    .pulse_active (pulse_active),
    .wr           (bus_wr),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .tune         (pll_tune),
    .acc_en       (acc_en),
    .used         (used),
    .tune_accept  (tune_accept)
  );

  ptc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (por_rst_n),
    .start  (tune_accept),
    .active (pulse_active)
  );

  assign hold_n    = por_rst_n && !pulse_active;
  assign rst_out_n = hold_n;
  assign int_rst_n = hold_n;
  assign pll_rst   = !hold_n;

  // R6: an accepted tuning write pulls the processor reset low next cycle
  a_r6_accept_resets: assert property (@(posedge clk) disable iff (!por_rst_n)
    tune_accept |=> !rst_out_n);
  // R4: the write-once flag rises only together with a reset pulse
  a_r4_flag_with_pulse: assert property (@(posedge clk) disable iff (!por_rst_n)
    $rose(used) |-> pulse_active);
  // R7: the enable bit stays clear while the pulse runs
  a_r7_en_clear_in_pulse: assert property (@(posedge clk) disable iff (!por_rst_n)
    pulse_active |-> !acc_en);
endmodule

// File: tb/tb_pll_tune_rst_ctrl.sv
`timescale 1ns/1ps
module tb_pll_tune_rst_ctrl;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned TUNE_W = 8;
  localparam logic [TUNE_W-1:0] TDEF = 8'h3C;
  localparam int unsigned PULSE = 5;

  logic clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [TUNE_W-1:0] pll_tune;
  logic pll_rst, rst_out_n, int_rst_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_tune_rst_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TUNE_W(TUNE_W),
    .TUNE_DEFAULT(TDEF), .PULSE_CYC(PULSE)
  ) dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_tune(pll_tune),
    .pll_rst(pll_rst), .rst_out_n(rst_out_n), .int_rst_n(int_rst_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [DATA_W-1:0] d);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    logic [DATA_W-1:0] d;
    sys_rst_n = 1'b0;
    #1;
    chk("R1 out low in reset", {29'd0, rst_out_n, int_rst_n, pll_rst}, 32'd1);
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync edge1 held", {31'd0, rst_out_n}, 32'd0);
    @(negedge clk);
    chk("R1 sync edge2 released", {29'd0, rst_out_n, int_rst_n, pll_rst}, 32'd6);
    bus_read(0, d);
    chk("R1 access clear", d, 32'd0);
    bus_read(1, d);
    chk("R8 tune default after reset", d, TDEF);
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    int n;
    @(negedge clk);
    do_reset();

    // R2: register map, read-only flag, unmapped addresses
    bus_write(2, 16'hFFFF);
    bus_write(3, 16'hFFFF);
    bus_read(2, d); chk("R2 unmapped 2 reads 0", d, 0);
    bus_read(3, d); chk("R2 unmapped 3 reads 0", d, 0);
    bus_read(0, d); chk("R2 unmapped write no effect", d, 0);
    bus_read(1, d); chk("R2 unmapped write tune", d, TDEF);
    bus_write(0, 16'hFFFF);
    bus_read(0, d); chk("R2 flag read-only", d, 1);
    bus_write(0, 0);
    bus_read(0, d); chk("R2 enable clears", d, 0);

    for (int v = 0; v < (1 << TUNE_W); v++) begin
      logic [TUNE_W-1:0] nv;
      nv = ~TUNE_W'(v);
      do_reset();
      // R3: refused while enable clear
      bus_write(1, int'(nv));
      chk("R3 no pulse", {31'd0, rst_out_n}, 1);
      bus_read(1, d); chk("R3 tune kept", d, TDEF);
      // R4: accepted write
      bus_write(0, 1);
      bus_write(1, v | 16'hAB00);
      n = 0;
      if (!rst_out_n) n++;
      chk("R6 int/pll during pulse", {30'd0, int_rst_n, pll_rst}, 1);
      chk("R10 pll_tune in pulse", pll_tune, v);
      bus_write(0, 1);          // R9 ignored during pulse
      if (!rst_out_n) n++;
      bus_read(1, d); chk("R10 tune read in pulse", d, v);
      bus_write(1, int'(nv));   // R9 ignored during pulse
      while (!rst_out_n && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk("R6 pulse length", n, PULSE);
      chk("R6 pll released", {30'd0, int_rst_n, pll_rst}, 2);
      bus_read(0, d); chk("R7 R9 en cleared flag kept", d, 2);
      bus_read(1, d); chk("R4 R7 tune kept", d, v);
      // R5: second write refused
      bus_write(0, 1);
      bus_read(0, d); chk("R5 re-enable", d, 3);
      bus_write(1, int'(nv));
      chk("R5 no second pulse", {31'd0, rst_out_n}, 1);
      @(negedge clk);
      chk("R5 no second pulse later", {31'd0, rst_out_n}, 1);
      chk("R5 tune unchanged", pll_tune, v);
    end

    // R8: after reset a new write is accepted again
    do_reset();
    bus_write(0, 1);
    bus_write(1, 16'h0011);
    chk("R8 rearmed pulse", {31'd0, rst_out_n}, 0);
    chk("R8 rearmed tune", pll_tune, 8'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule